// File: doc/BRIEF.md
# I2C SCL Period Generator

This block creates the serial clock for an I2C master. It holds two pairs of programmable counts, one for standard speed and one for fast speed, and a speed selector picks the pair in use. Every count is measured in cycles of the controller clock. The block drives an open-drain enable for SCL, where 1 pulls the line low. It reads back the sampled line so that a target holding SCL low stretches the clock.

A master sequencer asks for a START by pulsing `start_req`, and for a STOP by pulsing `stop_req` during a transfer. The block times the START hold, each low and high phase, and the STOP setup from the same counters. It gives the data shifter one-cycle strobes at four points: when SDA should fall for START, when SDA may change (first low cycle), when SDA should be sampled (middle of the high phase), and when SDA should rise for STOP.

Top module: `i2c_scl_timer`

## Requirements
- R1: After reset the block is idle. `scl_oe` is 0 and no strobe is asserted until a START is requested.
- R2: A low phase holds `scl_oe` at 1 for the effective low count plus 1 cycles, starting in the cycle SCL is first driven low. `upd_strb` pulses in that first low cycle. No two strobes are ever asserted in the same cycle.
- R3: A high phase lasts the effective high count plus 8 cycles, counted from the first cycle in which `scl_in` is sampled high while SCL is released. Each cycle that `scl_in` stays low after release lengthens the released time by one cycle.
- R4: `smp_strb` pulses once per high phase, at offset floor((high count + 8) / 2) from the first high-counted cycle.
- R5: On `start_req` in idle with enable set, `start_strb` pulses at once. SCL stays released for the effective high count plus 3 cycles, counted from that strobe cycle, before the first low phase.
- R6: A `stop_req` during a transfer lets the current high phase finish and then gives one more low phase. After that, SCL is released, and `stop_strb` pulses in the cycle that completes high count plus 3 cycles counted from the first high-sampled cycle. The block then returns to idle.
- R7: Count registers are picked by `cnt_sel`: 0 standard high, 1 standard low, 2 fast high, 3 fast low. Speed code 2'b10 selects the fast pair. Any other code, including 2'b01 and 2'b11, selects the standard pair.
- R8: A high count below 6 is used as 6, and a low count below 8 is used as 8.
- R9: Count and speed writes take effect only while `en` is 0. Writes made while enabled leave the timing unchanged.
- R10: When `en` is 0, SCL is released from the next cycle, the transfer is dropped, and `start_req` is ignored. A later START runs with fresh counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Controller enable; low clears the sequencer and opens the count registers for writing |
| cnt_we | input | 1 | Count register write strobe |
| cnt_sel | input | 2 | Count register index (R7) |
| cnt_wdata | input | CNT_W | Count value to write |
| spd_we | input | 1 | Speed code write strobe |
| spd_code | input | 2 | Speed code (R7) |
| start_req | input | 1 | Pulse to begin a transfer with a START |
| stop_req | input | 1 | Pulse to end the transfer with a STOP |
| scl_in | input | 1 | Sampled SCL line level |
| scl_oe | output | 1 | 1 pulls SCL low |
| smp_strb | output | 1 | Sample SDA now (middle of high phase) |
| upd_strb | output | 1 | Update SDA now (first low cycle) |
| start_strb | output | 1 | Drive SDA low for START |
| stop_strb | output | 1 | Release SDA for STOP |

## Verification
The bench targets the off-by-one points of each phase. These are the +1 on the low phase, the +8 on the high phase, the +3 on START hold and STOP setup, and the floor in the midpoint. A design that counted from the wrong cycle would shift every measured run by one. Clock stretching is applied on both ordinary high phases and the STOP setup. A design that started its high counter on release, rather than on the sampled high level, would produce released runs shorter by the stretch length. Counts below the minimum, writes while enabled, the unused speed code and a mid-transfer disable are each driven. These expose a missing clamp, a register bank that ignores the enable, a wrong default speed, or a sequencer that keeps SCL low after the enable drops.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;

    localparam int unsigned CNT_W_DEF  = 16;
    localparam int unsigned HI_MIN     = 6;
    localparam int unsigned LO_MIN     = 8;
    localparam int unsigned HI_EXTRA   = 8;
    localparam int unsigned LO_EXTRA   = 1;
    localparam int unsigned HOLD_EXTRA = 3;
    localparam int unsigned NUM_CREG   = 4;

    localparam logic [1:0] SPD_STD  = 2'b01;
    localparam logic [1:0] SPD_FAST = 2'b10;

    typedef enum logic [1:0] {
        CR_STD_HI = 2'd0,
        CR_STD_LO = 2'd1,
        CR_FST_HI = 2'd2,
        CR_FST_LO = 2'd3
    } creg_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_HOLD,
        PH_LOW,
        PH_HIGH,
        PH_STOP
    } phase_e;

    typedef struct packed {
        logic smp;
        logic upd;
        logic beg;
        logic fin;
    } strb_t;

endpackage

// File: rtl/sclgen_cfg.sv
module sclgen_cfg
    import sclgen_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF,
    parameter int unsigned LEN_W = CNT_W + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             cnt_we,
    input  logic [1:0]       cnt_sel,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             spd_we,
    input  logic [1:0]       spd_code,
    output logic [LEN_W-1:0] hi_len,
    output logic [LEN_W-1:0] lo_len,
    output logic [LEN_W-1:0] hold_len
);

    logic [CNT_W-1:0] creg_q [NUM_CREG];
    logic [1:0]       spd_q;
    logic             fast;
    logic [CNT_W-1:0] hi_raw, lo_raw, hi_eff, lo_eff;

    // One register per count, writable only while the controller is off.
    for (genvar g = 0; g < NUM_CREG; g++) begin : g_creg
        localparam logic [CNT_W-1:0] RST_VAL =
            (g % 2 == 1) ? CNT_W'(LO_MIN) : CNT_W'(HI_MIN);
        always_ff @(posedge clk) begin
            if (rst) begin
                creg_q[g] <= RST_VAL;
            end else if (!en && cnt_we && (cnt_sel == 2'(g))) begin
                creg_q[g] <= cnt_wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            spd_q <= SPD_STD;
        end else if (!en && spd_we) begin
            spd_q <= spd_code;
        end
    end

    always_comb begin
        fast   = (spd_q == SPD_FAST);
        hi_raw = fast ? creg_q[CR_FST_HI] : creg_q[CR_STD_HI];
        lo_raw = fast ? creg_q[CR_FST_LO] : creg_q[CR_STD_LO];
        hi_eff = (hi_raw < CNT_W'(HI_MIN)) ? CNT_W'(HI_MIN) : hi_raw;
        lo_eff = (lo_raw < CNT_W'(LO_MIN)) ? CNT_W'(LO_MIN) : lo_raw;
        hi_len   = LEN_W'(hi_eff) + LEN_W'(HI_EXTRA);
        lo_len   = LEN_W'(lo_eff) + LEN_W'(LO_EXTRA);
        hold_len = LEN_W'(hi_eff) + LEN_W'(HOLD_EXTRA);
    end

endmodule

// File: rtl/sclgen_seq.sv
module sclgen_seq
    import sclgen_pkg::*;
#(
    parameter int unsigned LEN_W = CNT_W_DEF + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             scl_in,
    input  logic [LEN_W-1:0] hi_len,
    input  logic [LEN_W-1:0] lo_len,
    input  logic [LEN_W-1:0] hold_len,
    output phase_e           ph,
    output logic [LEN_W-1:0] cnt,
    output logic             active,
    output logic             last_cyc
);

    phase_e           ph_q;
    logic [LEN_W-1:0] cnt_q;
    logic             hi_seen_q, last_q, stop_pend_q;
    logic             waits, stop_now;
    logic [LEN_W-1:0] cur_len;

    always_comb begin
        waits    = (ph_q == PH_HIGH) || (ph_q == PH_STOP);
        active   = (ph_q == PH_HOLD) || (ph_q == PH_LOW) ||
                   (waits && (hi_seen_q || scl_in));
        unique case (ph_q)
            PH_HOLD, PH_STOP: cur_len = hold_len;
            PH_LOW:           cur_len = lo_len;
            PH_HIGH:          cur_len = hi_len;
            default:          cur_len = LEN_W'(1);
        endcase
        last_cyc = active && (cnt_q == cur_len - LEN_W'(1));
        stop_now = stop_pend_q || stop_req;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ph_q        <= PH_IDLE;
            cnt_q       <= '0;
            hi_seen_q   <= 1'b0;
            last_q      <= 1'b0;
            stop_pend_q <= 1'b0;
        end else begin
            if (ph_q != PH_IDLE) stop_pend_q <= stop_now;
            if (ph_q == PH_IDLE) begin
                if (start_req) begin
                    ph_q  <= PH_HOLD;
                    cnt_q <= '0;
                end
            end else if (active) begin
                if (last_cyc) begin
                    cnt_q     <= '0;
                    hi_seen_q <= 1'b0;
                    unique case (ph_q)
                        PH_HOLD, PH_HIGH: begin
                            ph_q   <= PH_LOW;
                            last_q <= stop_now;
                        end
                        PH_LOW:  ph_q <= last_q ? PH_STOP : PH_HIGH;
                        default: begin
                            ph_q        <= PH_IDLE;
                            last_q      <= 1'b0;
                            stop_pend_q <= 1'b0;
                        end
                    endcase
                end else begin
                    cnt_q     <= cnt_q + LEN_W'(1);
                    hi_seen_q <= waits;
                end
            end
        end
    end

    assign ph  = ph_q;
    assign cnt = cnt_q;

endmodule

// File: rtl/sclgen_strb.sv
module sclgen_strb
    import sclgen_pkg::*;
#(
    parameter int unsigned LEN_W = CNT_W_DEF + 1
) (
    input  phase_e           ph,
    input  logic [LEN_W-1:0] cnt,
    input  logic             active,
    input  logic             last_cyc,
    input  logic [LEN_W-1:0] hi_len,
    output strb_t            strb,
    output logic             oe
);

    logic [LEN_W-1:0] mid;

    always_comb begin
        mid      = hi_len >> 1;
        oe       = (ph == PH_LOW);
        strb.smp = (ph == PH_HIGH) && active && (cnt == mid);
        strb.upd = (ph == PH_LOW)  && (cnt == '0);
        strb.beg = (ph == PH_HOLD) && (cnt == '0);
        strb.fin = (ph == PH_STOP) && last_cyc;
    end

endmodule

// File: rtl/i2c_scl_timer.sv
module i2c_scl_timer
    import sclgen_pkg::*;
#(
    parameter int unsigned CNT_W = CNT_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             cnt_we,
    input  logic [1:0]       cnt_sel,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             spd_we,
    input  logic [1:0]       spd_code,
    input  logic             start_req,
    input  logic             stop_req,
    input  logic             scl_in,
    output logic             scl_oe,
    output logic             smp_strb,
    output logic             upd_strb,
    output logic             start_strb,
    output logic             stop_strb
);

    localparam int unsigned LEN_W = CNT_W + 1;

    logic [LEN_W-1:0] hi_len, lo_len, hold_len;
    phase_e           ph;
    logic [LEN_W-1:0] cnt;
    logic             active, last_cyc;
    strb_t            strb;

    sclgen_cfg #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_cfg (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .cnt_we   (cnt_we),
        .cnt_sel  (cnt_sel),
        .cnt_wdata(cnt_wdata),
        .spd_we   (spd_we),
        .spd_code (spd_code),
        .hi_len   (hi_len),
        .lo_len   (lo_len),
        .hold_len (hold_len)
    );

    sclgen_seq #(.LEN_W(LEN_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .en       (en),
        .start_req(start_req),
        .stop_req (stop_req),
        .scl_in   (scl_in),
        .hi_len   (hi_len),
        .lo_len   (lo_len),
        .hold_len (hold_len),
        .ph       (ph),
        .cnt      (cnt),
        .active   (active),
        .last_cyc (last_cyc)
    );

    sclgen_strb #(.LEN_W(LEN_W)) u_strb (
        .ph      (ph),
        .cnt     (cnt),
        .active  (active),
        .last_cyc(last_cyc),
        .hi_len  (hi_len),
        .strb    (strb),
        .oe      (scl_oe)
    );

    assign smp_strb   = strb.smp;
    assign upd_strb   = strb.upd;
    assign start_strb = strb.beg;
    assign stop_strb  = strb.fin;

endmodule

// File: rtl/i2c_scl_timer_chk.sv
module i2c_scl_timer_chk #(
    parameter int unsigned LEN_W = 17
) (
    input logic             clk,
    input logic             rst,
    input logic             en,
    input logic             scl_in,
    input logic             scl_oe,
    input logic             smp_strb,
    input logic             upd_strb,
    input logic             start_strb,
    input logic             stop_strb,
    input logic [LEN_W-1:0] lo_len
);

    logic [LEN_W-1:0] low_run;

    always_ff @(posedge clk) begin
        if (rst) low_run <= '0;
        else     low_run <= scl_oe ? low_run + LEN_W'(1) : '0;
    end

    // R10
    off_release_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> !scl_oe);

    // R2
    low_entry_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_oe) |-> upd_strb);

    // R2
    low_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(scl_oe) && $past(en)) |-> (low_run == lo_len));

    // R2
    strb_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({smp_strb, upd_strb, start_strb, stop_strb}));

    // R4
    smp_released_chk: assert property (@(posedge clk) disable iff (rst)
        smp_strb |-> (!scl_oe && scl_in));

    // R5
    start_released_chk: assert property (@(posedge clk) disable iff (rst)
        start_strb |=> !scl_oe);

    // R6
    stop_idle_chk: assert property (@(posedge clk) disable iff (rst)
        stop_strb |=> (!scl_oe && !upd_strb && !smp_strb));

endmodule

bind i2c_scl_timer i2c_scl_timer_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .scl_in    (scl_in),
    .scl_oe    (scl_oe),
    .smp_strb  (smp_strb),
    .upd_strb  (upd_strb),
    .start_strb(start_strb),
    .stop_strb (stop_strb),
    .lo_len    (lo_len)
);

// File: tb/tb_i2c_scl_timer.sv
module tb_i2c_scl_timer;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 16;

    logic             clk = 1'b0;
    logic             rst, en, cnt_we, spd_we, start_req, stop_req;
    logic [1:0]       cnt_sel, spd_code;
    logic [CNT_W-1:0] cnt_wdata;
    logic             scl_in, scl_oe, smp_strb, upd_strb, start_strb, stop_strb;

    int total = 0;
    int bad   = 0;

    typedef enum int {EV_HOLD, EV_LOW, EV_HIGH, EV_MID, EV_STOP} ev_e;
    ev_e   q_kind[$];
    int    q_val[$];
    string q_req[$];

    int cyc = 0, str_left = 0, stretch_n = 0, smp_seen = 0;
    int t_start = 0, t_rise = 0, t_fall = 0;
    bit mon_on = 0, hold_pend = 0, prev_oe = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_in = ~scl_oe & (str_left == 0);

    i2c_scl_timer #(.CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .en(en),
        .cnt_we(cnt_we), .cnt_sel(cnt_sel), .cnt_wdata(cnt_wdata),
        .spd_we(spd_we), .spd_code(spd_code),
        .start_req(start_req), .stop_req(stop_req), .scl_in(scl_in),
        .scl_oe(scl_oe), .smp_strb(smp_strb), .upd_strb(upd_strb),
        .start_strb(start_strb), .stop_strb(stop_strb)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input ev_e k, input int v, input string req);
        q_kind.push_back(k);
        q_val.push_back(v);
        q_req.push_back(req);
    endtask

    task automatic emit(input ev_e k, input int v);
        ev_e   ek;
        int    ev;
        string er;
        if (q_kind.size() == 0) begin
            chk(1'b0, "unexpected event", int'(k), -1);
        end else begin
            ek = q_kind.pop_front();
            ev = q_val.pop_front();
            er = q_req.pop_front();
            chk(ek == k, {er, " kind"}, int'(k), int'(ek));
            chk(v == ev, er, v, ev);
        end
    endtask

    // Monitor: measures phase lengths and strobe offsets at the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (str_left > 0) str_left--;
        if (mon_on) begin
            if (start_strb) begin
                t_start   = cyc;
                hold_pend = 1;
            end
            if (scl_oe && !prev_oe) begin
                if (hold_pend) begin
                    emit(EV_HOLD, cyc - t_start);
                    hold_pend = 0;
                end else begin
                    emit(EV_HIGH, cyc - t_fall);
                end
                t_rise = cyc;
            end
            if (!scl_oe && prev_oe) begin
                emit(EV_LOW, cyc - t_rise);
                t_fall = cyc;
            end
            if (smp_strb) begin
                smp_seen++;
                emit(EV_MID, cyc - t_fall);
            end
            if (stop_strb) emit(EV_STOP, cyc - t_fall + 1);
        end
        if (!scl_oe && prev_oe) str_left = stretch_n;
        prev_oe = scl_oe;
    end

    task automatic set_cnt(input int idx, input int val);
        @(negedge clk);
        cnt_we = 1; cnt_sel = 2'(idx); cnt_wdata = CNT_W'(val);
        @(negedge clk);
        cnt_we = 0;
    endtask

    task automatic set_spd(input logic [1:0] code);
        @(negedge clk);
        spd_we = 1; spd_code = code;
        @(negedge clk);
        spd_we = 0;
    endtask

    // Driver: pushes the expected phase sequence, then runs one transfer.
    task automatic xfer(input int hi, input int lo, input int nb, input int s, input string tag);
        int base;
        stretch_n = s;
        push(EV_HOLD, hi + 3, {"R5 ", tag});
        push(EV_LOW, lo + 1, {"R2 ", tag});
        for (int i = 0; i < nb; i++) begin
            push(EV_MID, s + (hi + 8) / 2, {"R4 ", tag});
            push(EV_HIGH, s + hi + 8, {"R3 ", tag});
            push(EV_LOW, lo + 1, {"R2 ", tag});
        end
        push(EV_STOP, s + hi + 3, {"R6 ", tag});
        base = smp_seen;
        @(negedge clk); start_req = 1;
        @(negedge clk); start_req = 0;
        wait (smp_seen == base + nb);
        @(negedge clk); stop_req = 1;
        @(negedge clk); stop_req = 0;
        wait (q_kind.size() == 0);
        repeat (4) @(negedge clk);
        chk(!scl_oe, {"R6 idle after stop ", tag}, int'(scl_oe), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit quiet;
        rst = 1; en = 0; cnt_we = 0; spd_we = 0; start_req = 0; stop_req = 0;
        cnt_sel = 0; spd_code = 0; cnt_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 0;

        // R1: idle after reset, nothing asserted
        quiet = 1;
        repeat (6) begin
            @(negedge clk);
            if (scl_oe || smp_strb || upd_strb || start_strb || stop_strb) quiet = 0;
        end
        chk(quiet, "R1 reset idle", int'(quiet), 1);

        // standard pair, R7 index 0/1
        set_cnt(0, 10); set_cnt(1, 12); set_spd(2'b01);
        en = 1; mon_on = 1;
        xfer(10, 12, 2, 0, "std");
        // R3 stretch on high phases and stop setup
        xfer(10, 12, 1, 5, "stretch");

        // R7 fast pair selected by code 2'b10
        en = 0;
        set_cnt(2, 7); set_cnt(3, 9); set_spd(2'b10);
        en = 1;
        xfer(7, 9, 3, 0, "R7 fast");

        // R8 clamp below minimum
        en = 0;
        set_cnt(2, 2); set_cnt(3, 0);
        en = 1;
        xfer(6, 8, 1, 0, "R8 clamp");

        // R9 writes while enabled have no effect
        set_cnt(2, 30); set_cnt(3, 40); set_spd(2'b01);
        xfer(6, 8, 1, 0, "R9 ignored");

        // R7 code 2'b11 falls back to the standard pair
        en = 0;
        set_spd(2'b11);
        en = 1;
        xfer(10, 12, 1, 0, "R7 code3");

        // R10 disable mid-transfer, start while disabled ignored
        mon_on = 0;
        @(negedge clk); start_req = 1;
        @(negedge clk); start_req = 0;
        wait (scl_oe == 1'b1);
        @(negedge clk); en = 0;
        @(negedge clk);
        chk(!scl_oe, "R10 release after disable", int'(scl_oe), 0);
        quiet = 1;
        start_req = 1;
        repeat (30) begin
            @(negedge clk);
            start_req = 0;
            if (scl_oe || smp_strb || upd_strb || start_strb || stop_strb) quiet = 0;
        end
        chk(quiet, "R10 start ignored while disabled", int'(quiet), 1);
        en = 1; hold_pend = 0;
        @(negedge clk);
        mon_on = 1;
        xfer(10, 12, 1, 0, "R10 restart");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule